// File: doc/BRIEF.md
# SPI Master Byte Shifter

This block is the serial engine of a master-only SPI port. Each accepted transmit command sends one 8-bit frame. The block makes the serial clock from the system clock through a programmable divider. During the same transfer it drives the outgoing data line and samples the incoming one, so a received byte is always a by-product of a transmit. Reception has no path of its own.

Software selects the clock polarity, the clock phase, the bit order and the divider before it issues a command. The block copies these settings when the transfer starts. Longer words are built from several frames. Chip select, slave operation and any framing bits are left to the surrounding software. The block has no select output and carries no select state.

Top module: `spiByteShifter`

## Requirements
- R1: With divider value D on `cfgDiv`, every half period of `sclk` lasts D+1 system clocks. The first `sclk` edge comes D+1 clocks after the clock edge that accepts `txStart`.
- R2: A transfer has exactly 16 `sclk` edges and exactly 8 data bits in each direction. `mosi` carries only the data bits, with no start, identification or stop bit.
- R3: While no transfer runs, `sclk` rests at the level of `cfgCpol`. It follows that input one clock later.
- R4: With `cfgCpha`=0, the first data bit is on `mosi` from the clock after acceptance, before the first `sclk` edge. `miso` is sampled on the leading (odd-numbered) edges and `mosi` changes on the trailing edges.
- R5: With `cfgCpha`=1, `mosi` changes on the leading edges and `miso` is sampled on the trailing edges.
- R6: With `cfgLsbFirst`=0, bit 7 is sent and received first. With `cfgLsbFirst`=1, bit 0 goes first. In both cases `rxByte` shows the received bits in their natural positions.
- R7: `busy` is high from the clock after acceptance for 16*(D+1) clocks. `done` pulses for one clock in the cycle in which `busy` falls, and from that cycle `rxByte` holds the new byte until the next `done`.
- R8: A `txStart` that arrives while `busy` is high is ignored. The running transfer keeps its data, its length and its timing, and it produces only one `done`.
- R9: After a transfer, `mosi` holds the last bit sent until the next transfer drives a new one.
- R10: Polarity, phase, bit order, divider and `txByte` are sampled when `txStart` is accepted. Changes to them during a transfer do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; the block is held idle while it is low |
| cfgCpol | input | 1 | Idle level of the serial clock |
| cfgCpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfgLsbFirst | input | 1 | 1: bit 0 first; 0: bit 7 first |
| cfgDiv | input | DIV_W (8) | Divider D; half period = D+1 clocks |
| txStart | input | 1 | Transmit command; accepted only while idle |
| txByte | input | 8 | Byte to send, taken when the command is accepted |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock pulse at the end of a transfer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| rxByte | output | 8 | Byte received in the last transfer |

## Verification
A wrong edge counter shows up at the ports as a transfer that ends early or late: `done` arrives away from 16*(D+1) clocks, or the count of `sclk` edges in the frame is not 16. Either is seen within that same frame. A wrong divider count moves the first `sclk` edge away from D+1 clocks, which is visible one half period after the start. A wrong phase decode or shift direction corrupts the byte that a bench model of the peripheral captures from `mosi`, and the byte seen on `rxByte`, when `done` fires. A configuration copy that is not held shows up when settings change during a transfer.

// File: rtl/spiShiftPkg.sv
package spiShiftPkg;
  localparam int FRAME_BITS = 8;
  localparam int FRAME_EDGES = 2 * FRAME_BITS;
  localparam int EDGE_W = $clog2(FRAME_EDGES);

  // Strobes from control to datapath, valid for one clock each
  typedef struct packed {
    logic load;       // transfer accepted this cycle
    logic loadDrive;  // phase 0: put first bit out with the load
    logic drive;      // present the next bit on the output line
    logic sample;     // capture the input line
    logic finish;     // last edge of the frame
    logic lsbFirst;   // bit order in force for this transfer
  } shiftStrobeT;
endpackage

// File: rtl/spiShiftCtrl.sv
module spiShiftCtrl
  import spiShiftPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic             cfgLsbFirst,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             txStart,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output shiftStrobeT      strobes
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_EDGES - 1);

  logic             busyR, doneR, sclkR;
  logic [DIV_W-1:0] divCnt, divLat;
  logic             cpolLat, cphaLat, lsbLat;
  logic [EDGE_W-1:0] edgeIdx;

  logic startNow, tick, trailing, sampleNow, driveNow, lastEdge;

  always_comb begin
    startNow  = txStart && !busyR;
    tick      = busyR && (divCnt == divLat);
    trailing  = edgeIdx[0];
    sampleNow = tick && (cphaLat ? trailing : !trailing);
    driveNow  = tick && (cphaLat ? !trailing : (trailing && edgeIdx != LAST_EDGE));
    lastEdge  = tick && (edgeIdx == LAST_EDGE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      sclkR   <= 1'b0;
      divCnt  <= '0;
      divLat  <= '0;
      cpolLat <= 1'b0;
      cphaLat <= 1'b0;
      lsbLat  <= 1'b0;
      edgeIdx <= '0;
    end else begin
      doneR <= lastEdge;
      if (startNow) begin
        busyR   <= 1'b1;
        divCnt  <= '0;
        edgeIdx <= '0;
        divLat  <= cfgDiv;
        cpolLat <= cfgCpol;
        cphaLat <= cfgCpha;
        lsbLat  <= cfgLsbFirst;
        sclkR   <= cfgCpol;
      end else if (busyR) begin
        if (tick) begin
          divCnt  <= '0;
          sclkR   <= !sclkR;
          edgeIdx <= edgeIdx + 1'b1;
          if (lastEdge) busyR <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else begin
        sclkR <= cfgCpol;
      end
    end
  end

  always_comb begin
    strobes.load      = startNow;
    strobes.loadDrive = startNow && !cfgCpha;
    strobes.drive     = driveNow;
    strobes.sample    = sampleNow;
    strobes.finish    = lastEdge;
    strobes.lsbFirst  = busyR ? lsbLat : cfgLsbFirst;
  end

  assign busy = busyR;
  assign done = doneR;
  assign sclk = sclkR;

  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !busyR |=> (sclkR == $past(cfgCpol)));                            // R3
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && divCnt != divLat) |=> $stable(sclkR));                  // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);                                                // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyR) |-> doneR);                                          // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && txStart && !lastEdge) |=> (busyR && $stable(divLat)));  // R8
  AST_FRAME_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    lastEdge |=> (sclkR == cpolLat));                                 // R2
endmodule

// File: rtl/spiShiftPath.sv
module spiShiftPath
  import spiShiftPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  shiftStrobeT           strobes,
  input  logic [FRAME_BITS-1:0] txByte,
  input  logic                  miso,
  output logic                  mosi,
  output logic [FRAME_BITS-1:0] rxByte
);
  localparam int MSB = FRAME_BITS - 1;

  logic [MSB:0] txShift, rxShift, rxByteR;
  logic         mosiR;

  function automatic logic headOf(input logic [MSB:0] v, input logic lsb);
    return lsb ? v[0] : v[MSB];
  endfunction

  function automatic logic [MSB:0] advance(input logic [MSB:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  logic [MSB:0] rxNext;
  always_comb begin
    rxNext = strobes.lsbFirst ? {miso, rxShift[MSB:1]} : {rxShift[MSB-1:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      mosiR   <= 1'b0;
    end else if (strobes.load) begin
      if (strobes.loadDrive) begin
        mosiR   <= headOf(txByte, strobes.lsbFirst);
        txShift <= advance(txByte, strobes.lsbFirst);
      end else begin
        txShift <= txByte;
      end
    end else if (strobes.drive) begin
      mosiR   <= headOf(txShift, strobes.lsbFirst);
      txShift <= advance(txShift, strobes.lsbFirst);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxByteR <= '0;
    end else begin
      if (strobes.load)        rxShift <= '0;
      else if (strobes.sample) rxShift <= rxNext;
      if (strobes.finish)      rxByteR <= strobes.sample ? rxNext : rxShift;
    end
  end

  assign mosi   = mosiR;
  assign rxByte = rxByteR;

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadDrive || strobes.drive) |=> $stable(mosiR));        // R9
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(rxByteR));                            // R7
  AST_NO_DRIVE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.drive && strobes.sample));                              // R4
endmodule

// File: rtl/spiByteShifter.sv
module spiByteShifter
  import spiShiftPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic             cfgLsbFirst,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             txStart,
  input  logic [7:0]       txByte,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic [7:0]       rxByte
);
  shiftStrobeT strobes;

  spiShiftCtrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgLsbFirst(cfgLsbFirst),
    .cfgDiv(cfgDiv), .txStart(txStart),
    .busy(busy), .done(done), .sclk(sclk), .strobes(strobes)
  );

  spiShiftPath u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txByte(txByte), .miso(miso), .mosi(mosi), .rxByte(rxByte)
  );
endmodule

// File: tb/spiByteShifter_bench.sv
module spiByteShifter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgCpol = 1'b0, cfgCpha = 1'b0, cfgLsbFirst = 1'b0;
  logic [7:0] cfgDiv = 8'd0;
  logic       txStart = 1'b0;
  logic [7:0] txByte = 8'd0;
  logic       miso = 1'b0;
  logic       busy, done, sclk, mosi;
  logic [7:0] rxByte;

  always #10 clk = !clk;

  spiByteShifter u_spiByteShifter (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgLsbFirst(cfgLsbFirst), .cfgDiv(cfgDiv), .txStart(txStart),
    .txByte(txByte), .miso(miso), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .rxByte(rxByte)
  );

  typedef struct packed {
    logic [7:0] tx;
    logic [7:0] sl;
    logic [7:0] div;
    logic       cpol;
    logic       cpha;
    logic       lsb;
  } xferT;

  xferT expQ[$];
  int   cyc = 0;
  int   checks = 0, fails = 0, mChecks = 0, mFails = 0, wdFails = 0;
  logic [7:0] nextSlaveByte = 8'd0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic bitOf(input logic [7:0] b, input logic lsb, input int k);
    return lsb ? b[k] : b[7 - k];
  endfunction

  // Peripheral model: shifts miso and captures mosi on the edges the mode selects
  logic sCpol, sCpha, sLsb, prevBusy = 1'b0, prevSclk = 1'b0, leadEdge, isSample;
  logic [7:0] sByte, capByte;
  int edgeCnt, sampCnt, sendIdx, startCyc, firstEdgeCyc, endCyc;
  logic startMosi, startSclk;

  always @(negedge clk) begin
    if (busy && !prevBusy) begin
      sCpol = cfgCpol; sCpha = cfgCpha; sLsb = cfgLsbFirst; sByte = nextSlaveByte;
      edgeCnt = 0; sampCnt = 0; sendIdx = 0; capByte = 8'd0;
      startCyc = cyc; firstEdgeCyc = -1; startMosi = mosi; startSclk = sclk;
      if (!sCpha) begin
        miso = bitOf(sByte, sLsb, 0);
        sendIdx = 1;
      end
    end else if ((busy || done) && sclk != prevSclk) begin
      edgeCnt++;
      if (edgeCnt == 1) firstEdgeCyc = cyc;
      leadEdge = (prevSclk == sCpol);
      isSample = sCpha ? !leadEdge : leadEdge;
      if (isSample) begin
        if (sampCnt < 8) capByte[sLsb ? sampCnt : 7 - sampCnt] = mosi;
        sampCnt++;
      end else if (sendIdx < 8) begin
        miso = bitOf(sByte, sLsb, sendIdx);
        sendIdx++;
      end
    end
    if (done) endCyc = cyc;
    prevBusy = busy;
    prevSclk = sclk;
  end

  task automatic mchk(input bit ok, input string req, input string what, input int act, input int exp);
    mChecks++;
    if (!ok) begin
      mFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: checks each finished frame one clock after done, against the queue
  logic doneD = 1'b0;
  always @(negedge clk) begin
    if (doneD) begin
      if (expQ.size() == 0) begin
        mchk(1'b0, "R8", "done without pending command", 1, 0);
      end else begin
        xferT e;
        int per;
        e = expQ.pop_front();
        per = int'(e.div) + 1;
        mchk(rxByte == e.sl, e.cpha ? "R5" : "R4", "rxByte", rxByte, e.sl);
        mchk(capByte == e.tx, "R6", "byte seen on mosi", capByte, e.tx);
        mchk(edgeCnt == 16, "R2", "sclk edges", edgeCnt, 16);
        mchk(sampCnt == 8, "R2", "data bits", sampCnt, 8);
        mchk(endCyc - startCyc == 16 * per, "R7", "busy length", endCyc - startCyc, 16 * per);
        mchk(firstEdgeCyc - startCyc == per, "R1", "first edge delay", firstEdgeCyc - startCyc, per);
        mchk(startSclk == e.cpol, "R3", "sclk at start", startSclk, e.cpol);
        if (!e.cpha)
          mchk(startMosi == bitOf(e.tx, e.lsb, 0), "R4", "first bit before edge",
               startMosi, bitOf(e.tx, e.lsb, 0));
      end
    end
    doneD = done;
  end

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input int div,
                      input bit cpol, input bit cpha, input bit lsb,
                      input bit extraStart, input bit glitchCfg);
    xferT e;
    @(negedge clk);
    cfgCpol = cpol; cfgCpha = cpha; cfgLsbFirst = lsb; cfgDiv = 8'(div);
    repeat (2) @(negedge clk);
    chk(sclk == cpol, "R3", "idle sclk level", sclk, cpol);
    e.tx = tx; e.sl = sl; e.div = 8'(div); e.cpol = cpol; e.cpha = cpha; e.lsb = lsb;
    expQ.push_back(e);
    nextSlaveByte = sl;
    txByte = tx; txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0; txByte = ~tx;
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    if (extraStart) begin
      repeat (3) @(negedge clk);
      txByte = 8'h5A ^ tx; txStart = 1'b1;   // R8: must be ignored
      @(negedge clk);
      txStart = 1'b0;
    end
    if (glitchCfg) begin
      repeat (2) @(negedge clk);
      cfgDiv = 8'(div + 3); cfgLsbFirst = !lsb; cfgCpha = !cpha; cfgCpol = !cpol; // R10
    end
    while (!done) @(negedge clk);
    cfgCpol = cpol; cfgCpha = cpha; cfgLsbFirst = lsb; cfgDiv = 8'(div);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8", "single frame only", busy, 0);
    chk(mosi == bitOf(tx, lsb, 7), "R9", "mosi holds last bit", mosi, bitOf(tx, lsb, 7));
    chk(sclk == cpol, "R3", "sclk back at idle", sclk, cpol);
    chk(expQ.size() == 0, "R7", "frame reported", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R7", "reset busy/done", {busy, done}, 0);
    chk(sclk == 1'b0, "R3", "reset sclk", sclk, 0);
    chk(mosi == 1'b0 && rxByte == 8'd0, "R9", "reset mosi/rxByte", rxByte, 0);
    rstN = 1'b1;
    @(negedge clk);
    cfgCpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R3", "idle follows polarity", sclk, 1);
    xfer(8'hA5, 8'h3C, 0, 0, 0, 0, 0, 0);
    xfer(8'h81, 8'h7E, 1, 0, 1, 0, 0, 0);
    xfer(8'h1F, 8'hC4, 2, 1, 0, 1, 0, 0);
    xfer(8'h6B, 8'h96, 3, 1, 1, 1, 0, 0);
    xfer(8'hFF, 8'h00, 5, 0, 0, 1, 0, 0);
    xfer(8'h00, 8'hFF, 0, 0, 1, 0, 0, 0);
    xfer(8'hC3, 8'h2D, 2, 0, 0, 0, 1, 0);   // R8
    xfer(8'h4E, 8'hB1, 1, 1, 1, 0, 0, 1);   // R10
    xfer(8'h37, 8'hE8, 20, 0, 1, 1, 1, 1);  // R8, R10, R1 long divider
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mChecks, fails + mFails + wdFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    wdFails = 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mChecks + 1, fails + mFails + wdFails);
    $finish;
  end
endmodule